// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR flash and turns bus write cycles into operation requests. Each write carries an address and a 16-bit data word. The block walks through multi-cycle command sequences, checks each confirm value and target address, and then sends one request to a downstream array controller. The requests are block erase, lock, unlock, one-time-programmable register write, lock register write, status-pin configuration and buffered word program. It also sends suspend and resume requests. For the buffered program it gathers up to `DEPTH` words into an internal buffer, which the controller reads back by index.

A malformed sequence raises a one-clock error pulse. No request is issued in that case, and the decoder returns to idle. Once an operation has been requested, the decoder is busy until the controller pulses `ctl_done`. While busy, only suspend and resume are honoured.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset, `req_valid` and `seq_err` are 0, and the decoder is idle with no operation busy or suspended.
- R2: A write of 0x0020 followed by 0x00D0 in the same block (the address bits above the low `BLK_W`=8 bits are equal) issues op 1 (erase) with the first-cycle address. Any other confirm value, or a confirm address in another block, gives an error pulse and no request.
- R3: While an operation is busy, 0x00B0 issues op 2 (suspend) with its own address. While suspended, 0x00D0 issues op 3 (resume). 0x00B0 when nothing is busy, and 0x00D0 when idle and not suspended, are ignored.
- R4: 0x0060 followed by a second cycle in the same block issues op 4 (lock) for data 0x0001 or op 5 (unlock) for data 0x00D0. Any other value, or another block, is an error.
- R5: 0x00C0 followed by a data cycle at the identical address issues a register write. It is op 7 when the address equals `LOCKREG_ADDR` (0x0080) and op 6 otherwise, with `req_data` set to the second-cycle data. A different second address is an error.
- R6: 0x00B8 followed by any value issues op 8 (configuration), with `req_data` set to that value.
- R7: The buffered program is 0x00EB at the start address, then a sub-opcode, then N-1, then N data cycles, then 0x00D0 in the start block. It issues op 9 with `req_addr` = start, `req_data` = sub-opcode and `req_count` = N. Each data word is stored at buffer index `addr[IDX_W-1:0]` and can be read through `buf_rd_idx`/`buf_rd_data`.
- R8: A count cycle value of `DEPTH` or more is an error, and the decoder returns to idle.
- R9: A data cycle whose address differs from the start address above the low `IDX_W` bits is an error. The sequence is abandoned, and a following 0x00D0 issues nothing.
- R10: After any request other than suspend or resume, every write except the suspend/resume codes is ignored until `ctl_done`.
- R11: A request or error appears in the clock after the edge that samples the deciding write, and lasts exactly one clock.
- R12: A first-cycle data value that is not a command code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| ctl_done | input | 1 | Controller finished the current operation |
| buf_rd_idx | input | 4 | Buffer read index |
| req_valid | output | 1 | One-clock request pulse |
| req_op | output | 4 | Operation code of the request |
| req_addr | output | 16 | Target address of the request |
| req_data | output | 16 | Data or sub-opcode of the request |
| req_count | output | 5 | Word count for buffered program |
| seq_err | output | 1 | One-clock sequence error pulse |
| buf_rd_data | output | 16 | Buffer word at `buf_rd_idx` |

## Verification
On every cycle, the assertions check four things. A busy decoder emits only suspend or resume. An error never coincides with a request. A resume is only ever preceded by a suspended state. Every request leaves the sequencer idle with a legal word count. Some behaviours can only be shown by the bench scenarios. These are the decoding of each confirm value and address, the ignoring of stray codes, and the discarding of an abandoned buffer sequence. The buffer contents are checked after a sweep over every word count.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_ERASE   = 4'd1,
    OP_SUSPEND = 4'd2,
    OP_RESUME  = 4'd3,
    OP_LOCK    = 4'd4,
    OP_UNLOCK  = 4'd5,
    OP_OTP     = 4'd6,
    OP_LOCKREG = 4'd7,
    OP_CFG     = 4'd8,
    OP_BUFPROG = 4'd9
  } fcd_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE,
    ST_LOCK,
    ST_REG,
    ST_CFG,
    ST_SUBOP,
    ST_COUNT,
    ST_DATA,
    ST_CONF
  } fcd_state_e;

  localparam logic [15:0] CODE_ERASE   = 16'h0020;
  localparam logic [15:0] CODE_CONFIRM = 16'h00D0;
  localparam logic [15:0] CODE_SUSPEND = 16'h00B0;
  localparam logic [15:0] CODE_LOCKSET = 16'h0060;
  localparam logic [15:0] CODE_LOCKON  = 16'h0001;
  localparam logic [15:0] CODE_REGPROG = 16'h00C0;
  localparam logic [15:0] CODE_CFG     = 16'h00B8;
  localparam logic [15:0] CODE_BUFPROG = 16'h00EB;

endpackage

// File: rtl/fcd_wbuf.sv
module fcd_wbuf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] words [DEPTH];

  // storage array: no reset, written only under the clock enable
  always_ff @(posedge clk) begin
    if (we) begin
      words[widx] <= wdata;
    end
  end

  assign rdata = words[ridx];

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 16,
  parameter int          BLK_W        = 8,
  parameter int          DEPTH        = 16,
  parameter logic [15:0] LOCKREG_ADDR = 16'h0080,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_done,
  output logic              req_valid,
  output fcd_op_e           req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [CNT_W-1:0]  req_count,
  output logic              seq_err,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_widx,
  output logic [DATA_W-1:0] buf_wdata
);

  fcd_state_e        state_q, state_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [DATA_W-1:0] subop_q, subop_d;
  logic [IDX_W-1:0]  cntm1_q, cntm1_d;
  logic [IDX_W-1:0]  left_q, left_d;
  logic              busy_q, busy_d;
  logic              susp_q, susp_d;

  logic              issue, err_d, set_busy;
  fcd_op_e           op_d;
  logic [ADDR_W-1:0] raddr_d;
  logic [DATA_W-1:0] rdata_d;
  logic [CNT_W-1:0]  rcnt_d;

  logic same_blk, in_win;
  assign same_blk = (wr_addr[ADDR_W-1:BLK_W] == start_q[ADDR_W-1:BLK_W]);
  assign in_win   = (wr_addr[ADDR_W-1:IDX_W] == start_q[ADDR_W-1:IDX_W]);

  assign buf_widx  = wr_addr[IDX_W-1:0];
  assign buf_wdata = wr_data;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    start_d  = start_q;
    subop_d  = subop_q;
    cntm1_d  = cntm1_q;
    left_d   = left_q;
    busy_d   = busy_q;
    susp_d   = susp_q;
    issue    = 1'b0;
    set_busy = 1'b0;
    err_d    = 1'b0;
    op_d     = OP_NONE;
    raddr_d  = start_q;
    rdata_d  = wr_data;
    rcnt_d   = '0;
    buf_we   = 1'b0;

    if (wr_en) begin
      if (busy_q) begin
        if (!susp_q && wr_data == DATA_W'(CODE_SUSPEND)) begin
          issue   = 1'b1;
          op_d    = OP_SUSPEND;
          raddr_d = wr_addr;
          susp_d  = 1'b1;
        end else if (susp_q && wr_data == DATA_W'(CODE_CONFIRM)) begin
          issue   = 1'b1;
          op_d    = OP_RESUME;
          raddr_d = wr_addr;
          susp_d  = 1'b0;
        end
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            start_d = wr_addr;
            if (wr_data == DATA_W'(CODE_ERASE))        state_d = ST_ERASE;
            else if (wr_data == DATA_W'(CODE_LOCKSET)) state_d = ST_LOCK;
            else if (wr_data == DATA_W'(CODE_REGPROG)) state_d = ST_REG;
            else if (wr_data == DATA_W'(CODE_CFG))     state_d = ST_CFG;
            else if (wr_data == DATA_W'(CODE_BUFPROG)) state_d = ST_SUBOP;
          end
          ST_ERASE: begin
            state_d = ST_IDLE;
            if (same_blk && wr_data == DATA_W'(CODE_CONFIRM)) begin
              issue = 1'b1;
              op_d  = OP_ERASE;
            end else begin
              err_d = 1'b1;
            end
          end
          ST_LOCK: begin
            state_d = ST_IDLE;
            if (same_blk && wr_data == DATA_W'(CODE_LOCKON)) begin
              issue = 1'b1;
              op_d  = OP_LOCK;
            end else if (same_blk && wr_data == DATA_W'(CODE_CONFIRM)) begin
              issue = 1'b1;
              op_d  = OP_UNLOCK;
            end else begin
              err_d = 1'b1;
            end
          end
          ST_REG: begin
            state_d = ST_IDLE;
            if (wr_addr == start_q) begin
              issue = 1'b1;
              op_d  = (start_q == ADDR_W'(LOCKREG_ADDR)) ? OP_LOCKREG : OP_OTP;
            end else begin
              err_d = 1'b1;
            end
          end
          ST_CFG: begin
            state_d = ST_IDLE;
            issue   = 1'b1;
            op_d    = OP_CFG;
          end
          ST_SUBOP: begin
            subop_d = wr_data;
            state_d = ST_COUNT;
          end
          ST_COUNT: begin
            if (wr_data < DATA_W'(DEPTH)) begin
              cntm1_d = wr_data[IDX_W-1:0];
              left_d  = wr_data[IDX_W-1:0];
              state_d = ST_DATA;
            end else begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end
          end
          ST_DATA: begin
            if (in_win) begin
              buf_we = 1'b1;
              if (left_q == '0) state_d = ST_CONF;
              else              left_d  = left_q - 1'b1;
            end else begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end
          end
          ST_CONF: begin
            state_d = ST_IDLE;
            if (same_blk && wr_data == DATA_W'(CODE_CONFIRM)) begin
              issue   = 1'b1;
              op_d    = OP_BUFPROG;
              rdata_d = subop_q;
              rcnt_d  = CNT_W'(cntm1_q) + 1'b1;
            end else begin
              err_d = 1'b1;
            end
          end
          default: state_d = ST_IDLE;
        endcase
        set_busy = issue;
      end
    end

    if (set_busy) begin
      busy_d = 1'b1;
    end else if (ctl_done && busy_q) begin
      busy_d = 1'b0;
      susp_d = 1'b0;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      busy_q    <= 1'b0;
      susp_q    <= 1'b0;
      req_valid <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      busy_q    <= busy_d;
      susp_q    <= susp_d;
      req_valid <= issue;
      seq_err   <= err_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= '0;
      subop_q   <= '0;
      cntm1_q   <= '0;
      left_q    <= '0;
      req_op    <= OP_NONE;
      req_addr  <= '0;
      req_data  <= '0;
      req_count <= '0;
    end else begin
      if (wr_en) begin
        start_q <= start_d;
        subop_q <= subop_d;
        cntm1_q <= cntm1_d;
        left_q  <= left_d;
      end
      if (issue) begin
        req_op    <= op_d;
        req_addr  <= raddr_d;
        req_data  <= rdata_d;
        req_count <= rcnt_d;
      end
    end
  end

  assert_busy_gate_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(busy_q) && req_valid) |-> (req_op == OP_SUSPEND || req_op == OP_RESUME));

  assert_err_no_req_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    seq_err |-> !req_valid);

  assert_resume_needs_suspend_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_op == OP_RESUME) |-> $past(susp_q));

  assert_count_legal_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_op == OP_BUFPROG) |-> (req_count >= 1 && req_count <= CNT_W'(DEPTH)));

  assert_req_leaves_idle_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |-> (state_q == ST_IDLE));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 16,
  parameter int          BLK_W        = 8,
  parameter int          DEPTH        = 16,
  parameter logic [15:0] LOCKREG_ADDR = 16'h0080,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_done,
  input  logic [IDX_W-1:0]  buf_rd_idx,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [CNT_W-1:0]  req_count,
  output logic              seq_err,
  output logic [DATA_W-1:0] buf_rd_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  logic              rst_ni;
  fcd_op_e           op_w;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_widx;
  logic [DATA_W-1:0] buf_wdata;

  assign rst_ni = rst_sync_q[1];
  assign req_op = op_w;

  fcd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
    .DEPTH(DEPTH), .LOCKREG_ADDR(LOCKREG_ADDR)
  ) u_seq (
    .clk(clk), .rst_ni(rst_ni),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_done(ctl_done),
    .req_valid(req_valid), .req_op(op_w), .req_addr(req_addr),
    .req_data(req_data), .req_count(req_count), .seq_err(seq_err),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata)
  );

  fcd_wbuf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .we(buf_we), .widx(buf_widx), .wdata(buf_wdata),
    .ridx(buf_rd_idx), .rdata(buf_rd_data)
  );

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        ctl_done;
  logic [3:0]  buf_rd_idx;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [15:0] req_addr;
  logic [15:0] req_data;
  logic [4:0]  req_count;
  logic        seq_err;
  logic [15:0] buf_rd_data;

  int total = 0;
  int bad   = 0;

  logic        g_v, g_err;
  logic [3:0]  g_op;
  logic [15:0] g_addr, g_data;
  logic [4:0]  g_cnt;

  flash_cmd_decoder #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl_done(ctl_done), .buf_rd_idx(buf_rd_idx),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_count(req_count), .seq_err(seq_err),
    .buf_rd_data(buf_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic grab();
    g_v = req_valid; g_err = seq_err; g_op = req_op;
    g_addr = req_addr; g_data = req_data; g_cnt = req_count;
  endtask

  // one bus write; outputs captured after the edge that sampled it
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    grab();
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    grab();
  endtask

  task automatic done_pulse();
    @(negedge clk); ctl_done = 1'b1;
    @(negedge clk); ctl_done = 1'b0;
  endtask

  task automatic exp_req(input string tag, input logic [3:0] op,
                         input logic [15:0] a, input logic [15:0] d);
    check({tag, " valid"}, {31'd0, g_v}, 32'd1);
    check({tag, " op"}, {28'd0, g_op}, {28'd0, op});
    check({tag, " addr"}, {16'd0, g_addr}, {16'd0, a});
    check({tag, " data"}, {16'd0, g_data}, {16'd0, d});
    check({tag, " err"}, {31'd0, g_err}, 32'd0);
  endtask

  task automatic exp_none(input string tag);
    check({tag, " no req"}, {31'd0, g_v}, 32'd0);
    check({tag, " no err"}, {31'd0, g_err}, 32'd0);
  endtask

  task automatic exp_err(input string tag);
    check({tag, " err"}, {31'd0, g_err}, 32'd1);
    check({tag, " no req"}, {31'd0, g_v}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ctl_done = 1'b0; buf_rd_idx = '0;
    repeat (3) @(negedge clk);
    grab();
    exp_none("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    grab();
    exp_none("R1 after reset");

    // R12: stray first-cycle codes; R3: idle confirm / suspend ignored
    wr(16'h0100, 16'h1234); exp_none("R12 stray code");
    wr(16'h0100, 16'h00D0); exp_none("R3 idle confirm");
    wr(16'h0100, 16'h00B0); exp_none("R3 idle suspend");

    // R2: erase across several blocks, confirm at another offset in block
    for (int b = 0; b < 4; b++) begin
      logic [15:0] base;
      base = 16'(b * 16'h0300 + 16'h0011);
      wr(base, 16'h0020); exp_none("R2 erase setup");
      wr(base ^ 16'h00F0, 16'h00D0); exp_req("R2 erase", 4'd1, base, 16'h00D0);
      idle_cycle(); exp_none("R11 pulse one clock");
      done_pulse();
    end
    wr(16'h0500, 16'h0020); wr(16'h0600, 16'h00D0); exp_err("R2 erase other block");
    idle_cycle(); exp_none("R11 err one clock");
    wr(16'h0500, 16'h0020); wr(16'h0500, 16'h00FF); exp_err("R2 erase bad confirm");

    // R4: sweep the second-cycle value of lock/unlock
    for (int v = 0; v < 256; v++) begin
      wr(16'h1234, 16'h0060);
      wr(16'h12A0, 16'(v));
      if (v == 1) begin
        exp_req("R4 lock", 4'd4, 16'h1234, 16'h0001); done_pulse();
      end else if (v == 16'hD0) begin
        exp_req("R4 unlock", 4'd5, 16'h1234, 16'h00D0); done_pulse();
      end else begin
        exp_err("R4 bad value");
      end
    end
    wr(16'h1234, 16'h0060); wr(16'h1334, 16'h0001); exp_err("R4 other block");

    // R5: register programs
    wr(16'h0080, 16'h00C0); wr(16'h0080, 16'hBEEF);
    exp_req("R5 lock register", 4'd7, 16'h0080, 16'hBEEF); done_pulse();
    wr(16'h0010, 16'h00C0); wr(16'h0010, 16'h5A5A);
    exp_req("R5 otp register", 4'd6, 16'h0010, 16'h5A5A); done_pulse();
    wr(16'h0010, 16'h00C0); wr(16'h0011, 16'h5A5A); exp_err("R5 address mismatch");

    // R6: configuration
    wr(16'h0000, 16'h00B8); wr(16'h0000, 16'h0003);
    exp_req("R6 config", 4'd8, 16'h0000, 16'h0003); done_pulse();

    // R7: every word count
    for (int n = 1; n <= DEPTH; n++) begin
      wr(16'h4A35, 16'h00EB);
      wr(16'h4A35, 16'(16'h00A0 + n));
      wr(16'h4A35, 16'(n - 1)); exp_none("R7 count cycle");
      for (int i = 0; i < n; i++) begin
        wr(16'h4A30 | 16'((i * 5) % DEPTH), 16'(n * 256 + i));
        exp_none("R7 data cycle");
      end
      wr(16'h4A00, 16'h00D0);
      exp_req("R7 buffered program", 4'd9, 16'h4A35, 16'(16'h00A0 + n));
      check("R7 count", {27'd0, g_cnt}, 32'(n));
      for (int i = 0; i < n; i++) begin
        buf_rd_idx = 4'((i * 5) % DEPTH);
        #1;
        check("R7 buffer word", {16'd0, buf_rd_data}, 32'(16'(n * 256 + i)));
      end
      done_pulse();
    end

    // R8: count too large
    wr(16'h4A35, 16'h00EB); wr(16'h4A35, 16'h0000);
    wr(16'h4A35, 16'(DEPTH)); exp_err("R8 count too large");
    wr(16'h4A35, 16'h00D0); exp_none("R8 back to idle");

    // R9: address outside the buffer window
    wr(16'h4A35, 16'h00EB); wr(16'h4A35, 16'h0000); wr(16'h4A35, 16'h0001);
    wr(16'h4A31, 16'h1111); exp_none("R9 first word");
    wr(16'h4A45, 16'h2222); exp_err("R9 outside window");
    wr(16'h4A35, 16'h00D0); exp_none("R9 discarded");

    // R7 bad confirm
    wr(16'h4A35, 16'h00EB); wr(16'h4A35, 16'h0000); wr(16'h4A35, 16'h0000);
    wr(16'h4A33, 16'h7777); wr(16'h4A35, 16'h00D1); exp_err("R7 bad confirm");

    // R10 / R3: busy gating with suspend and resume
    wr(16'h0700, 16'h0020); wr(16'h0700, 16'h00D0);
    exp_req("R10 erase", 4'd1, 16'h0700, 16'h00D0);
    wr(16'h0720, 16'h0020); exp_none("R10 busy ignores setup");
    wr(16'h0720, 16'h00D0); exp_none("R10 busy ignores confirm");
    wr(16'h0001, 16'h00B0); exp_req("R3 suspend", 4'd2, 16'h0001, 16'h00B0);
    wr(16'h0002, 16'h00B0); exp_none("R3 second suspend");
    wr(16'h0003, 16'h00D0); exp_req("R3 resume", 4'd3, 16'h0003, 16'h00D0);
    wr(16'h0004, 16'h00D0); exp_none("R3 second resume");
    done_pulse();
    wr(16'h0800, 16'h00B0); exp_none("R3 suspend after done");
    wr(16'h0800, 16'h0020); wr(16'h0801, 16'h00D0);
    exp_req("R10 accepted after done", 4'd1, 16'h0800, 16'h00D0);
    done_pulse();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule